// File: doc/BRIEF.md
# Multiplexed Display Word Capture Scanner

This block scans a bank of eight data words held behind an external multiplexer and keeps a positive-true copy of each word for indicator drivers. A word-select counter steps through every slot in turn. The block drives the slot number to the multiplexer on an active-low select bus. It waits a programmable number of settle cycles so the returned word is stable. It then fires a decoded one-hot load strobe that captures the inverted, active-low data bus into the storage register for that slot.

Each storage register holds its contents until its own slot comes round again, and it drives its output at all times. A one-cycle frame pulse marks each completed pass over all slots. The scan clock runs freely. The nominal rate is 500 kHz, but the logic does not depend on the frequency.

Top module: `disp_scan_capture`

## Requirements
- R1: After reset the slot count is 0. Each slot is held for SETTLE+1 clock cycles. The count then advances by one in ascending order and wraps from 7 back to 0.
- R2: `mux_sel_no` is always the bitwise inverse of the current slot count, so slot 0 reads 3'b111 and slot 7 reads 3'b000.
- R3: `load_stb_o` has bit N high (one-hot) only in the last cycle of the dwell on slot N, which is after SETTLE cycles on that slot. In every other cycle it is zero.
- R4: On the clock edge that ends a strobe cycle for slot N, `word_o[N]` takes the bitwise inverse of `mux_data_ni`. `word_o[N]` occupies bits 8N+7 down to 8N of the output.
- R5: A storage register keeps its value between its own loads. Changes on `mux_data_ni` in non-strobe cycles, or during the strobe of another slot, leave it unchanged.
- R6: `frame_done_o` is high for exactly one cycle: the first cycle after the count wraps from 7 to 0.
- R7: While `rst_ni` is low (asynchronous, active low), the count is 0, `mux_sel_no` is 3'b111, all words are 0x00, and both `load_stb_o` and `frame_done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_sel_no | output | 3 | Active-low word select to external multiplexer |
| mux_data_ni | input | 8 | Active-low data word returned by multiplexer |
| load_stb_o | output | 8 | One-hot per-slot load strobe |
| word_o | output | 64 | Eight stored positive-true words, slot N at bits 8N+7:8N |
| frame_done_o | output | 1 | One-cycle pulse after each 7-to-0 wrap |

## Verification
The bench builds the block with SETTLE=2 instead of the default of 1. Each slot then dwells for three cycles, so the strobe must skip two settle cycles, and an off-by-one in the settle counter shows up as a misplaced strobe or a wrong capture. The behavioural multiplexer model returns new data in every cycle during one scenario. This reaches the case where only the strobe-cycle value may be stored. A reset asserted in the middle of a scan checks that the counter restarts at slot 0 with cleared words.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int unsigned DEF_NUM_WORDS = 8;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_SETTLE    = 1;
endpackage

// File: rtl/disp_scan_seq.sv
module disp_scan_seq #(
  parameter int unsigned NUM_WORDS = disp_scan_pkg::DEF_NUM_WORDS,
  parameter int unsigned SETTLE    = disp_scan_pkg::DEF_SETTLE,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS),
  localparam int unsigned DLY_W    = $clog2(SETTLE + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SEL_W-1:0] sel_o,
  output logic             load_o,
  output logic             frame_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_WORDS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [DLY_W-1:0] dly_q;
  logic             frame_q;

  // load cycle is the final cycle of the dwell
  assign load_o  = (dly_q == DLY_W'(SETTLE));
  assign sel_o   = sel_q;
  assign frame_o = frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      dly_q   <= '0;
      frame_q <= 1'b0;
    end else if (load_o) begin
      dly_q   <= '0;
      sel_q   <= (sel_q == LAST) ? '0 : sel_q + SEL_W'(1);
      frame_q <= (sel_q == LAST);
    end else begin
      dly_q   <= dly_q + DLY_W'(1);
      frame_q <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_scan_dec.sv
module disp_scan_dec #(
  parameter int unsigned NUM_WORDS = disp_scan_pkg::DEF_NUM_WORDS,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 en_i,
  output logic [NUM_WORDS-1:0] stb_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
    assign stb_o[i] = en_i && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/disp_scan_store.sv
module disp_scan_store #(
  parameter int unsigned NUM_WORDS = disp_scan_pkg::DEF_NUM_WORDS,
  parameter int unsigned DATA_W    = disp_scan_pkg::DEF_DATA_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_WORDS-1:0]              stb_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  word_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       word_q <= '0;
      else if (stb_i[i]) word_q <= data_i;
    end
    assign word_o[i] = word_q;
  end
endmodule

// File: rtl/disp_scan_capture.sv
module disp_scan_capture #(
  parameter int unsigned NUM_WORDS = disp_scan_pkg::DEF_NUM_WORDS,
  parameter int unsigned DATA_W    = disp_scan_pkg::DEF_DATA_W,
  parameter int unsigned SETTLE    = disp_scan_pkg::DEF_SETTLE,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  output logic [SEL_W-1:0]                  mux_sel_no,
  input  logic [DATA_W-1:0]                 mux_data_ni,
  output logic [NUM_WORDS-1:0]              load_stb_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  word_o,
  output logic                              frame_done_o
);
  logic [SEL_W-1:0]  sel;
  logic              load;
  logic [DATA_W-1:0] data_pos;

  disp_scan_seq #(.NUM_WORDS(NUM_WORDS), .SETTLE(SETTLE)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_o  (sel),
    .load_o (load),
    .frame_o(frame_done_o)
  );

  disp_scan_dec #(.NUM_WORDS(NUM_WORDS)) u_dec (
    .sel_i(sel),
    .en_i (load),
    .stb_o(load_stb_o)
  );

  assign mux_sel_no = ~sel;
  assign data_pos   = ~mux_data_ni;

  disp_scan_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (load_stb_o),
    .data_i(data_pos),
    .word_o(word_o)
  );
endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [SEL_W-1:0]                  mux_sel_no,
  input logic [DATA_W-1:0]                 mux_data_ni,
  input logic [NUM_WORDS-1:0]              load_stb_o,
  input logic [NUM_WORDS-1:0][DATA_W-1:0]  word_o,
  input logic                              frame_done_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_WORDS - 1);

  a_r3_stb_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_stb_o));

  a_r3_stb_matches_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_o != '0) |-> load_stb_o == (NUM_WORDS'(1) << (~mux_sel_no)));

  a_r1_advance_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_o != '0) |=> (~mux_sel_no) ==
      (($past(~mux_sel_no) == LAST) ? '0 : $past(~mux_sel_no) + SEL_W'(1)));

  a_r1_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_o == '0) |=> $stable(mux_sel_no));

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_o != '0) |=> word_o[$past(~mux_sel_no)] == $past(~mux_data_ni));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_o == '0) |=> $stable(word_o));

  a_r6_frame_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_o[NUM_WORDS-1] |=> frame_done_o);

  a_r6_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ((~mux_sel_no) == '0) ##1 !frame_done_o);
endmodule

bind disp_scan_capture disp_scan_chk #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mux_sel_no  (mux_sel_no),
  .mux_data_ni (mux_data_ni),
  .load_stb_o  (load_stb_o),
  .word_o      (word_o),
  .frame_done_o(frame_done_o)
);

// File: tb/sim_disp_scan_capture.sv
module sim_disp_scan_capture;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 2;
  localparam int DW = S + 1;
  localparam int FR = 8 * DW;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [2:0]      mux_sel_no;
  logic [7:0]      mux_data_ni;
  logic [7:0]      load_stb_o;
  logic [7:0][7:0] word_o;
  logic            frame_done_o;

  logic [7:0]      pat [8];
  logic [7:0][7:0] exp_w;
  int n = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural external multiplexer, active-low in and out
  assign mux_data_ni = ~pat[~mux_sel_no];

  disp_scan_capture #(.NUM_WORDS(8), .DATA_W(8), .SETTLE(S)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mux_sel_no(mux_sel_no),
    .mux_data_ni(mux_data_ni), .load_stb_o(load_stb_o),
    .word_o(word_o), .frame_done_o(frame_done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s n=%0d actual=%h expected=%h", tag, n, act, exp);
    end
  endtask

  task automatic check_all();
    int ph = n % DW;
    int sl = (n / DW) % 8;
    logic [7:0] es = (ph == S) ? (8'd1 << sl) : 8'd0;
    logic ef = (n > 0) && (n % FR == 0);
    chk(mux_sel_no == ~3'(sl), "R1 R2 select", 64'(mux_sel_no), 64'(~3'(sl)));
    chk(load_stb_o == es, "R3 strobe", 64'(load_stb_o), 64'(es));
    chk(frame_done_o == ef, "R6 frame", 64'(frame_done_o), 64'(ef));
    chk(word_o == exp_w, "R4 R5 words", word_o, exp_w);
  endtask

  task automatic step();
    int ph = n % DW;
    int sl = (n / DW) % 8;
    bit cap = (ph == S);
    logic [7:0] cd = pat[sl];
    @(posedge clk_i);
    @(negedge clk_i);
    n++;
    if (cap) exp_w[sl] = cd;
    check_all();
  endtask

  task automatic check_reset_state(input string tag);
    chk(mux_sel_no == 3'b111, {tag, " R7 select"}, 64'(mux_sel_no), 64'h7);
    chk(load_stb_o == 8'h00, {tag, " R7 strobe"}, 64'(load_stb_o), 64'h0);
    chk(frame_done_o == 1'b0, {tag, " R7 frame"}, 64'(frame_done_o), 64'h0);
    chk(word_o == '0, {tag, " R7 words"}, word_o, 64'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) pat[i] = 8'hA0 + 8'(i);
    exp_w = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_reset_state("t_reset");
    rst_ni = 1'b1;
    n = 0;
    check_all();
  endtask

  task automatic t_static_frames();
    for (int i = 0; i < 2 * FR; i++) step();
  endtask

  task automatic t_churn();
    logic [7:0] lf = 8'h5D;
    for (int i = 0; i < 3 * FR + 5; i++) begin
      for (int k = 0; k < 8; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        pat[k] = lf ^ 8'(k * 37);
      end
      step();
    end
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 8; i++) pat[i] = ~(8'h11 * 8'(i));
    for (int i = 0; i < 10; i++) step();
    #1 rst_ni = 1'b0;
    #1;
    exp_w = '0;
    check_reset_state("t_mid_reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    check_all();
    for (int i = 0; i < FR + 7; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_static_frames();
    t_churn();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule